// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block puts a small configuration register space behind two consecutive byte-wide I/O addresses. The lower address is the index port and the one above it is the data port. A host first selects a register by writing its number to the index port, then reads or writes that register through the data port. The base address is one of two fixed values, picked by a strap input.

The register space stays closed until the host writes an unlock byte to the index port twice in a row. A closing byte written to the index port shuts it again. While the space is open it offers three things: a logical-device select register, read-only identification bytes for the device, its revision and its manufacturer, and a window of indices that is passed to downstream function blocks. The window carries the selected device number, the register index and read and write strobes. A downstream block decodes the device number and answers the window read in the same cycle.

Top module: `cfg_keyed_port`

## Requirements
- R1: With `base_sel`=0 the index port is at 0x002E and the data port at 0x002F. With `base_sel`=1 they are at 0x004E and 0x004F. At any other address `io_hit` is 0, `io_rdata` is 0x00, and reads and writes change nothing.
- R2: Two index-port writes of 0x87 with no other index-port write between them open the space. `cfg_open` goes high in the cycle after the second write. Data-port accesses between the two writes do not break the sequence.
- R3: While the space is closed, an index-port write of any value other than 0x87 restarts the unlock sequence, so a later single 0x87 does not open it.
- R4: While the space is open, an index-port write of 0xAA closes it: `cfg_open` is low from the next cycle, and the stored index does not change.
- R5: While the space is closed, reads of either port return 0xFF. Data-port writes are ignored: `ld_wr` stays low and `ld_num` keeps its value.
- R6: While the space is open, an index-port write of any value other than 0xAA stores that value as the current index. It shows on `ld_addr` and is returned by index-port reads.
- R7: Index 0x07 is the logical-device select. It can be written and read back through the data port, and its value drives `ld_num`.
- R8: Indices 0x20 and 0x21 return the 16-bit device ID, high byte at 0x20. Index 0x22 returns the revision byte. Indices 0x23 and 0x24 return 0x19 and 0x34. Data-port writes to these indices have no effect.
- R9: For indices 0x30 and above, a data-port write raises `ld_wr` in the same cycle with `ld_wdata` equal to the written byte. A data-port read raises `ld_rd` in the same cycle and returns `ld_rdata`.
- R10: While the space is open, data-port reads of any other index (below 0x30 and not 0x07 or 0x20 to 0x24) return 0x00.
- R11: After reset the space is closed, the index is 0x00 and `ld_num` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| base_sel | input | 1 | Base address strap: 0 selects 0x2E, 1 selects 0x4E |
| io_addr | input | 16 | Host I/O address |
| io_wr | input | 1 | Host write strobe, one cycle per write |
| io_rd | input | 1 | Host read strobe, one cycle per read |
| io_wdata | input | 8 | Host write byte |
| io_rdata | output | 8 | Read byte, valid in the same cycle as `io_rd` |
| io_hit | output | 1 | Address matches the index or data port |
| cfg_open | output | 1 | Configuration space is unlocked |
| ld_num | output | 8 | Selected logical device |
| ld_addr | output | 8 | Current index, presented to the window |
| ld_wdata | output | 8 | Window write byte |
| ld_wr | output | 1 | Window write strobe |
| ld_rd | output | 1 | Window read strobe |
| ld_rdata | input | 8 | Window read byte from the downstream block |

## Verification
Some rules are checked by the assertions on every cycle:
- `cfg_open` can only rise right after an index write of the unlock byte.
- A closing byte always shuts the space, and a wrong byte while closed returns the sequencer to its start.
- A closed port reads as 0xFF and never strobes the window.
- The device select stays fixed while the space is closed.

Other behaviour can only be shown by the bench's scenarios. These are the exact unlock orderings (a broken pair, data accesses inside a pair), the identification byte order, the read-only handling of those bytes, the value returned for unmapped indices, and the move of both ports when the strap changes. A behavioural model compares all outputs in every cycle.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;

    typedef enum logic [1:0] {
        KEY_LOCKED = 2'd0,
        KEY_HALF   = 2'd1,
        KEY_OPEN   = 2'd2
    } key_state_e;

    typedef struct packed {
        logic [7:0] index;
        logic [7:0] ldsel;
    } reg_state_t;

endpackage

// File: rtl/cfgp_decode.sv
module cfgp_decode #(
    parameter int                ADDR_W = 16,
    parameter logic [ADDR_W-1:0] BASE_A = 16'h002E,
    parameter logic [ADDR_W-1:0] BASE_B = 16'h004E
) (
    input  logic              base_sel,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    output logic              idx_wr,
    output logic              idx_rd,
    output logic              dat_wr,
    output logic              dat_rd,
    output logic              hit
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] base;
    logic              idx_hit;
    logic              dat_hit;

    always_comb begin
        base    = base_sel ? BASE_B : BASE_A;
        idx_hit = (io_addr == base);
        dat_hit = (io_addr == (base + ONE));
        idx_wr  = idx_hit && io_wr;
        idx_rd  = idx_hit && io_rd;
        dat_wr  = dat_hit && io_wr;
        dat_rd  = dat_hit && io_rd;
        hit     = idx_hit || dat_hit;
    end

endmodule

// File: rtl/cfgp_key_fsm.sv
module cfgp_key_fsm
    import cfgp_pkg::*;
#(
    parameter logic [7:0] UNLOCK_KEY = 8'h87,
    parameter logic [7:0] LOCK_KEY   = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       idx_wr,
    input  logic [7:0] wdata,
    output logic       open
);
    key_state_e state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (idx_wr) begin
            unique case (state_q)
                KEY_LOCKED: state_d = (wdata == UNLOCK_KEY) ? KEY_HALF : KEY_LOCKED;
                KEY_HALF:   state_d = (wdata == UNLOCK_KEY) ? KEY_OPEN : KEY_LOCKED;
                KEY_OPEN:   state_d = (wdata == LOCK_KEY) ? KEY_LOCKED : KEY_OPEN;
                default:    state_d = KEY_LOCKED;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KEY_LOCKED;
        else        state_q <= state_d;
    end

    assign open = (state_q == KEY_OPEN);

    // R2
    open_needs_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(open) |-> $past(idx_wr && wdata == UNLOCK_KEY));

    // R4
    lock_closes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (open && idx_wr && wdata == LOCK_KEY) |=> !open);

    // R3
    wrong_key_restarts_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!open && idx_wr && wdata != UNLOCK_KEY) |=> (state_q == KEY_LOCKED));

endmodule

// File: rtl/cfgp_regfile.sv
module cfgp_regfile
    import cfgp_pkg::*;
#(
    parameter logic [15:0] DEV_ID    = 16'h0A51,
    parameter logic [7:0]  DEV_REV   = 8'h03,
    parameter logic [15:0] MFG_ID    = 16'h1934,
    parameter logic [7:0]  LDSEL_IDX = 8'h07,
    parameter logic [7:0]  ID_BASE   = 8'h20,
    parameter logic [7:0]  WIN_BASE  = 8'h30,
    parameter logic [7:0]  LOCK_KEY  = 8'hAA
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       open,
    input  logic       idx_wr,
    input  logic       idx_rd,
    input  logic       dat_wr,
    input  logic       dat_rd,
    input  logic [7:0] wdata,
    input  logic [7:0] ld_rdata,
    output logic [7:0] rdata,
    output logic [7:0] ld_num,
    output logic [7:0] ld_addr,
    output logic       ld_wr,
    output logic       ld_rd
);
    localparam int          ID_N    = 5;
    localparam logic [39:0] ID_PACK = {DEV_ID, DEV_REV, MFG_ID};

    reg_state_t st_d, st_q;

    logic [ID_N-1:0] id_hit;
    logic [7:0]      id_byte [ID_N];
    logic [7:0]      id_rdata;
    logic            in_window;
    logic [7:0]      cfg_rdata;

    for (genvar g = 0; g < ID_N; g++) begin : g_id
        assign id_hit[g]  = (st_q.index == (ID_BASE + 8'(g)));
        assign id_byte[g] = ID_PACK[39 - 8*g -: 8];
    end

    always_comb begin
        id_rdata = 8'h00;
        for (int i = 0; i < ID_N; i++) begin
            if (id_hit[i]) id_rdata = id_rdata | id_byte[i];
        end
    end

    assign in_window = (st_q.index >= WIN_BASE);

    always_comb begin
        if (st_q.index == LDSEL_IDX) cfg_rdata = st_q.ldsel;
        else if (|id_hit)            cfg_rdata = id_rdata;
        else if (in_window)          cfg_rdata = ld_rdata;
        else                         cfg_rdata = 8'h00;
    end

    always_comb begin
        st_d = st_q;
        if (open && idx_wr && wdata != LOCK_KEY) st_d.index = wdata;
        if (open && dat_wr && st_q.index == LDSEL_IDX) st_d.ldsel = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        if (idx_rd)      rdata = open ? st_q.index : 8'hFF;
        else if (dat_rd) rdata = open ? cfg_rdata : 8'hFF;
        else             rdata = 8'h00;
    end

    assign ld_wr   = open && dat_wr && in_window;
    assign ld_rd   = open && dat_rd && in_window;
    assign ld_num  = st_q.ldsel;
    assign ld_addr = st_q.index;

    // R5
    window_write_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ld_wr || ld_rd) |-> open);

    // R5
    ldsel_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !open |=> $stable(ld_num));

endmodule

// File: rtl/cfg_keyed_port.sv
module cfg_keyed_port
    import cfgp_pkg::*;
#(
    parameter int          ADDR_W     = 16,
    parameter logic [15:0] BASE_A     = 16'h002E,
    parameter logic [15:0] BASE_B     = 16'h004E,
    parameter logic [7:0]  UNLOCK_KEY = 8'h87,
    parameter logic [7:0]  LOCK_KEY   = 8'hAA,
    parameter logic [15:0] DEV_ID     = 16'h0A51,
    parameter logic [7:0]  DEV_REV    = 8'h03,
    parameter logic [15:0] MFG_ID     = 16'h1934,
    parameter logic [7:0]  WIN_BASE   = 8'h30
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              base_sel,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_wr,
    input  logic              io_rd,
    input  logic [7:0]        io_wdata,
    output logic [7:0]        io_rdata,
    output logic              io_hit,
    output logic              cfg_open,
    output logic [7:0]        ld_num,
    output logic [7:0]        ld_addr,
    output logic [7:0]        ld_wdata,
    output logic              ld_wr,
    output logic              ld_rd,
    input  logic [7:0]        ld_rdata
);
    logic idx_wr, idx_rd, dat_wr, dat_rd;

    cfgp_decode #(
        .ADDR_W (ADDR_W),
        .BASE_A (ADDR_W'(BASE_A)),
        .BASE_B (ADDR_W'(BASE_B))
    ) u_decode (
        .base_sel (base_sel),
        .io_addr  (io_addr),
        .io_wr    (io_wr),
        .io_rd    (io_rd),
        .idx_wr   (idx_wr),
        .idx_rd   (idx_rd),
        .dat_wr   (dat_wr),
        .dat_rd   (dat_rd),
        .hit      (io_hit)
    );

    cfgp_key_fsm #(
        .UNLOCK_KEY (UNLOCK_KEY),
        .LOCK_KEY   (LOCK_KEY)
    ) u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .idx_wr (idx_wr),
        .wdata  (io_wdata),
        .open   (cfg_open)
    );

    cfgp_regfile #(
        .DEV_ID   (DEV_ID),
        .DEV_REV  (DEV_REV),
        .MFG_ID   (MFG_ID),
        .WIN_BASE (WIN_BASE),
        .LOCK_KEY (LOCK_KEY)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .open     (cfg_open),
        .idx_wr   (idx_wr),
        .idx_rd   (idx_rd),
        .dat_wr   (dat_wr),
        .dat_rd   (dat_rd),
        .wdata    (io_wdata),
        .ld_rdata (ld_rdata),
        .rdata    (io_rdata),
        .ld_num   (ld_num),
        .ld_addr  (ld_addr),
        .ld_wr    (ld_wr),
        .ld_rd    (ld_rd)
    );

    assign ld_wdata = io_wdata;

    // R5
    locked_reads_ff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((idx_rd || dat_rd) && !cfg_open) |-> (io_rdata == 8'hFF));

    // R1
    miss_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_hit |-> (io_rdata == 8'h00 && !ld_wr && !ld_rd));

endmodule

// File: tb/cfg_keyed_port_test.sv
`timescale 1ns/1ps
module cfg_keyed_port_test;
    localparam int CLK_HALF = 10;

    logic        clk = 0;
    logic        rst_n = 0;
    logic        base_sel = 0;
    logic [15:0] io_addr = '0;
    logic        io_wr = 0;
    logic        io_rd = 0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        io_hit;
    logic        cfg_open;
    logic [7:0]  ld_num, ld_addr, ld_wdata;
    logic        ld_wr, ld_rd;
    logic [7:0]  ld_rdata = 8'h6B;

    int tests = 0;
    int fails = 0;

    // behavioural model: 0 closed, 1 one key seen, 2 open
    int m_state = 0;
    int m_idx = 0;
    int m_ld = 0;

    always #CLK_HALF clk = ~clk;

    cfg_keyed_port uut (
        .clk(clk), .rst_n(rst_n), .base_sel(base_sel), .io_addr(io_addr),
        .io_wr(io_wr), .io_rd(io_rd), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_hit(io_hit), .cfg_open(cfg_open), .ld_num(ld_num), .ld_addr(ld_addr),
        .ld_wdata(ld_wdata), .ld_wr(ld_wr), .ld_rd(ld_rd), .ld_rdata(ld_rdata)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic int data_value(input int idx);
        case (idx)
            8'h07:   return m_ld;
            8'h20:   return 8'h0A;
            8'h21:   return 8'h51;
            8'h22:   return 8'h03;
            8'h23:   return 8'h19;
            8'h24:   return 8'h34;
            default: return (idx >= 8'h30) ? int'(ld_rdata) : 0;
        endcase
    endfunction

    task automatic cycle(input string tag, input int a, input bit w, input bit r, input int d);
        int base, e_rd, e_hit;
        bit is_idx, is_dat, opn;
        @(negedge clk);
        io_addr = 16'(a); io_wr = w; io_rd = r; io_wdata = 8'(d);
        #2;
        base   = base_sel ? 'h4E : 'h2E;
        is_idx = (a == base);
        is_dat = (a == base + 1);
        opn    = (m_state == 2);
        e_hit  = (is_idx || is_dat) ? 1 : 0;
        e_rd   = 0;
        if (r && is_idx) e_rd = opn ? m_idx : 'hFF;
        if (r && is_dat) e_rd = opn ? data_value(m_idx) : 'hFF;
        check(tag, "io_rdata", int'(io_rdata), e_rd);
        check(tag, "io_hit", int'(io_hit), e_hit);
        check(tag, "cfg_open", int'(cfg_open), int'(opn));
        check(tag, "ld_num", int'(ld_num), m_ld);
        check(tag, "ld_addr", int'(ld_addr), m_idx);
        check(tag, "ld_wr", int'(ld_wr), int'(opn && w && is_dat && m_idx >= 'h30));
        check(tag, "ld_rd", int'(ld_rd), int'(opn && r && is_dat && m_idx >= 'h30));
        if (ld_wr) check(tag, "ld_wdata", int'(ld_wdata), d);
        @(posedge clk);
        if (w && is_idx) begin
            if (m_state == 2) begin
                if (d == 'hAA) m_state = 0;
                else m_idx = d;
            end else if (m_state == 1) m_state = (d == 'h87) ? 2 : 0;
            else m_state = (d == 'h87) ? 1 : 0;
        end else if (w && is_dat && opn && m_idx == 'h07) m_ld = d;
    endtask

    task automatic idle(input string tag);
        cycle(tag, 0, 0, 0, 0);
    endtask

    initial begin
        #4_000_000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1;

        // R11 reset state
        idle("R11");

        // R5 locked port: reads give FF, writes ignored
        cycle("R5", 'h2F, 0, 1, 0);
        cycle("R5", 'h2E, 0, 1, 0);
        cycle("R5", 'h2F, 1, 0, 'h42);
        idle("R5");

        // R1 key bytes at the alternate base are not seen while strap is 0
        cycle("R1", 'h4E, 1, 0, 'h87);
        cycle("R1", 'h4E, 1, 0, 'h87);
        cycle("R1", 'h4F, 0, 1, 0);
        idle("R1");

        // R3 broken pair, then single key
        cycle("R3", 'h2E, 1, 0, 'h87);
        cycle("R3", 'h2E, 1, 0, 'h55);
        cycle("R3", 'h2E, 1, 0, 'h87);
        idle("R3");
        cycle("R3", 'h2E, 1, 0, 'h10);
        idle("R3");

        // R2 pair with a data access between the two keys
        cycle("R2", 'h2E, 1, 0, 'h87);
        cycle("R2", 'h2F, 0, 1, 0);
        cycle("R2", 'h2E, 1, 0, 'h87);
        idle("R2");

        // R8 identification bytes
        for (int i = 'h20; i <= 'h24; i++) begin
            cycle("R8", 'h2E, 1, 0, i);
            cycle("R8", 'h2F, 0, 1, 0);
        end
        cycle("R8", 'h2E, 1, 0, 'h21);
        cycle("R8", 'h2F, 1, 0, 'hEE);
        cycle("R8", 'h2F, 0, 1, 0);

        // R7 device select
        cycle("R7", 'h2E, 1, 0, 'h07);
        cycle("R7", 'h2F, 1, 0, 'h03);
        cycle("R7", 'h2F, 0, 1, 0);
        idle("R7");

        // R9 window forwarding
        cycle("R9", 'h2E, 1, 0, 'h31);
        cycle("R9", 'h2F, 1, 0, 'h9C);
        cycle("R9", 'h2F, 0, 1, 0);
        ld_rdata = 8'hD2;
        cycle("R9", 'h2E, 1, 0, 'hFF);
        cycle("R9", 'h2F, 0, 1, 0);

        // R6 index readback
        cycle("R6", 'h2E, 1, 0, 'h44);
        cycle("R6", 'h2E, 0, 1, 0);

        // R10 unmapped indices
        cycle("R10", 'h2E, 1, 0, 'h10);
        cycle("R10", 'h2F, 0, 1, 0);
        cycle("R10", 'h2E, 1, 0, 'h2F);
        cycle("R10", 'h2F, 0, 1, 0);
        cycle("R10", 'h2E, 1, 0, 'h25);
        cycle("R10", 'h2F, 0, 1, 0);

        // R4 close; index and device select kept
        cycle("R4", 'h2E, 1, 0, 'hAA);
        idle("R4");
        cycle("R4", 'h2F, 1, 0, 'h09);
        cycle("R4", 'h2F, 0, 1, 0);

        // R1 strap moved to the alternate base
        @(negedge clk) base_sel = 1;
        cycle("R1", 'h2E, 1, 0, 'h87);
        cycle("R1", 'h2E, 1, 0, 'h87);
        idle("R1");
        cycle("R1", 'h4E, 1, 0, 'h87);
        cycle("R1", 'h4E, 1, 0, 'h87);
        cycle("R1", 'h4E, 1, 0, 'h23);
        cycle("R1", 'h4F, 0, 1, 0);
        cycle("R1", 'h2F, 0, 1, 0);
        cycle("R1", 'h4E, 1, 0, 'hAA);
        idle("R1");

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule